// File: doc/BRIEF.md
# Condition-Flag Data-Processing ALU

This block is the execution stage of a 32-bit data-processing pipeline. It takes a 4-bit operation code and two operands. The first operand comes from a register. The second has already passed through a shifter stage. From these it produces a result, a write enable for that result and the next values of the four condition flags: negative, zero, carry and overflow.

Sixteen operations are covered. Eight are logical: AND, exclusive OR, OR, move, bit clear, move-not, and the two test forms. For these, the carry flag comes from the shifter and the overflow flag is left as it was. The other eight are arithmetic: add, add with carry, subtract, reverse subtract, the two carry-in subtract forms, and the two compare forms. For these, both carry and overflow come from the adder.

The four compare and test codes update the flags but never write a result. The block is purely combinational. It sits between the shifter output and the register write-back.

Top module: `dp_flag_alu`

## Requirements
- R1: Logical codes give `result` as follows: 0000 = opa AND opb, 0001 = opa XOR opb, 1100 = opa OR opb, 1101 = opb, 1110 = opa AND NOT opb, 1111 = NOT opb.
- R2: Arithmetic codes give `result` as follows, with c being `flags_in[1]`: 0010 = opa−opb, 0011 = opb−opa, 0100 = opa+opb, 0101 = opa+opb+c, 0110 = opa−opb+c−1, 0111 = opb−opa+c−1. All are computed modulo 2^32.
- R3: Codes 1000, 1001, 1010 and 1011 compute as 0000, 0001, 0010 and 0100 respectively. They hold `result_we` low and update the flags even when `set_flags` is low. Every other code drives `result_we` high.
- R4: For a code outside 1000–1011 with `set_flags` low, `flags_out` equals `flags_in`. The flags are packed as {N,Z,C,V} in bits 3..0.
- R5: When `dest_pc` is high, `flags_out` equals `flags_in` for every code.
- R6: When the flags update, N (bit 3) equals bit 31 of `result`, and Z (bit 2) is 1 exactly when `result` is all zeros.
- R7: When a logical code updates the flags, V (bit 0) keeps its input value. C (bit 1) takes `sh_carry`, or keeps its input value when `sh_keep_c` is high.
- R8: When an arithmetic code updates the flags, C is the adder carry-out, with subtraction done by adding the inverted operand, so C=1 means no borrow. V is 1 when the two adder operands share a sign and the sum's sign differs from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opa | input | 32 | First operand (register) |
| opb | input | 32 | Second operand (from shifter) |
| sh_carry | input | 1 | Shifter carry-out |
| sh_keep_c | input | 1 | Shift was a zero-amount left shift; keep C |
| flags_in | input | 4 | Current {N,Z,C,V} |
| set_flags | input | 1 | Update flags |
| dest_pc | input | 1 | Destination is the program counter |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result is to be written |
| flags_out | output | 4 | Next {N,Z,C,V} |

## Verification
The checker assumes every input is a settled, two-valued level whenever a property is evaluated. This holds because the block has no state, so each observation depends only on the present input vector. The bench changes inputs in one step from a task and samples only after a settling delay, so no half-updated vector is ever judged. The random sweep drives every code with and without `set_flags` and `dest_pc`, and with both values of `sh_keep_c`. This keeps the checker's conditions on the flag-update class reachable from all sides.

// File: rtl/dp_flag_alu.sv
module dp_flag_alu #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sh_carry,
  input  logic             sh_keep_c,
  input  logic [3:0]       flags_in,
  input  logic             set_flags,
  input  logic             dest_pc,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags_out
);
  localparam int MSB = WIDTH - 1;

  logic is_test, is_arith, swap, invert, cin, upd;
  logic [WIDTH-1:0] x, y, sum;
  logic             cout, ovf, c_next, v_next;

  assign is_test  = (op[3:2] == 2'b10);
  assign is_arith = (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  assign swap     = (op == 4'b0011) || (op == 4'b0111);
  assign invert   = (op == 4'b0010) || (op == 4'b0011) || (op == 4'b0110) ||
                    (op == 4'b0111) || (op == 4'b1010);

  always_comb begin
    unique case (op)
      4'b0010, 4'b0011, 4'b1010: cin = 1'b1;
      4'b0101, 4'b0110, 4'b0111: cin = flags_in[1];
      default:                   cin = 1'b0;
    endcase
  end

  assign x = swap ? opb : opa;
  assign y = invert ? ~(swap ? opa : opb) : (swap ? opa : opb);
  assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  always_comb begin
    unique case (op)
      4'b0000, 4'b1000: result = opa & opb;
      4'b0001, 4'b1001: result = opa ^ opb;
      4'b1100:          result = opa | opb;
      4'b1101:          result = opb;
      4'b1110:          result = opa & ~opb;
      4'b1111:          result = ~opb;
      default:          result = sum;
    endcase
  end

  assign result_we = !is_test;
  assign upd       = (set_flags || is_test) && !dest_pc;
  assign c_next    = is_arith ? cout : (sh_keep_c ? flags_in[1] : sh_carry);
  assign v_next    = is_arith ? ovf  : flags_in[0];
  assign flags_out = upd ? {result[MSB], (result == '0), c_next, v_next} : flags_in;
endmodule

// File: rtl/dp_flag_alu_chk.sv
module dp_flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             sh_carry,
  input logic             sh_keep_c,
  input logic [3:0]       flags_in,
  input logic             set_flags,
  input logic             dest_pc,
  input logic [WIDTH-1:0] result,
  input logic             result_we,
  input logic [3:0]       flags_out
);
  logic test_op, logic_op, changes;
  assign test_op  = (op[3:2] == 2'b10);
  assign logic_op = (op[3:1] == 3'b000) || (op[3:1] == 3'b100) || (op[3:2] == 2'b11);
  assign changes  = (set_flags || test_op) && !dest_pc;

  always_comb begin
    AST_TEST_NO_WRITE: assert (result_we == !test_op) else $error("R3 write enable"); // R3
    if (!set_flags && !test_op)
      AST_HOLD_WITHOUT_S: assert (flags_out == flags_in) else $error("R4 flags moved"); // R4
    if (dest_pc)
      AST_PC_KEEPS_FLAGS: assert (flags_out == flags_in) else $error("R5 flags moved"); // R5
    if (changes)
      AST_NZ_FROM_RESULT: assert (flags_out[3] == result[WIDTH-1] && flags_out[2] == (result == '0)) else $error("R6 N/Z"); // R6
    if (changes && logic_op)
      AST_LOGIC_KEEPS_V: assert (flags_out[0] == flags_in[0] &&
                                 flags_out[1] == (sh_keep_c ? flags_in[1] : sh_carry)) else $error("R7 C/V"); // R7
    if (changes && op == 4'b0100)
      AST_ADD_OVERFLOW: assert (flags_out[0] == ((opa[WIDTH-1] == opb[WIDTH-1]) && (result[WIDTH-1] != opa[WIDTH-1]))) else $error("R8 V"); // R8
  end
endmodule

bind dp_flag_alu dp_flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op(op), .opa(opa), .opb(opb), .sh_carry(sh_carry), .sh_keep_c(sh_keep_c),
  .flags_in(flags_in), .set_flags(set_flags), .dest_pc(dest_pc),
  .result(result), .result_we(result_we), .flags_out(flags_out)
);

// File: tb/dp_flag_alu_tb.sv
module dp_flag_alu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic        sh_carry, sh_keep_c, set_flags, dest_pc;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dp_flag_alu u_dut (
    .op(op), .opa(opa), .opb(opb), .sh_carry(sh_carry), .sh_keep_c(sh_keep_c),
    .flags_in(flags_in), .set_flags(set_flags), .dest_pc(dest_pc),
    .result(result), .result_we(result_we), .flags_out(flags_out)
  );

  task automatic drive(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic s, input logic pc,
                       input logic shc, input logic keep);
    op = o; opa = a; opb = b; flags_in = f; set_flags = s; dest_pc = pc;
    sh_carry = shc; sh_keep_c = keep;
    #5;
  endtask

  task automatic expect_out(input string req, input logic [31:0] er,
                            input logic ew, input logic [3:0] ef);
    checks++;
    if (result !== er || result_we !== ew || flags_out !== ef) begin
      fails++;
      $display("FAIL %s op=%b: got res=%h we=%b fl=%b, exp res=%h we=%b fl=%b",
               req, op, result, result_we, flags_out, er, ew, ef);
    end
  endtask

  function automatic logic [37:0] model(input logic [3:0] o, input logic [31:0] a,
      input logic [31:0] b, input logic [3:0] f, input logic s, input logic pc,
      input logic shc, input logic keep);
    logic [32:0] wide;
    logic [31:0] r;
    logic arith, c, v, we;
    arith = 1'b1; c = 1'b0; v = 1'b0;
    case (o)
      4'h2, 4'hA: wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
      4'h3:       wide = {1'b0, b} + {1'b0, ~a} + 33'd1;
      4'h4, 4'hB: wide = {1'b0, a} + {1'b0, b};
      4'h5:       wide = {1'b0, a} + {1'b0, b} + {32'd0, f[1]};
      4'h6:       wide = {1'b0, a} + {1'b0, ~b} + {32'd0, f[1]};
      4'h7:       wide = {1'b0, b} + {1'b0, ~a} + {32'd0, f[1]};
      default:  begin wide = '0; arith = 1'b0; end
    endcase
    case (o)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC:       r = a | b;
      4'hD:       r = b;
      4'hE:       r = a & ~b;
      4'hF:       r = ~b;
      default:    r = wide[31:0];
    endcase
    if (arith) begin
      logic [31:0] p, q;
      p = (o == 4'h3 || o == 4'h7) ? b : a;
      q = (o == 4'h4 || o == 4'h5 || o == 4'hB) ? b :
          ((o == 4'h3 || o == 4'h7) ? ~a : ~b);
      c = wide[32];
      v = (p[31] == q[31]) && (r[31] != p[31]);
    end else begin
      c = keep ? f[1] : shc;
      v = f[0];
    end
    we = (o[3:2] != 2'b10);
    if ((s || !we) && !pc) return {r, we, 1'b0, r[31], (r == 32'd0), c, v};
    return {r, we, 1'b0, f};
  endfunction

  task automatic check_model(input string req);
    logic [37:0] m;
    m = model(op, opa, opb, flags_in, set_flags, dest_pc, sh_carry, sh_keep_c);
    expect_out(req, m[37:6], m[5], m[3:0]);
  endtask

  task automatic t_idle;
    drive(4'hD, 32'd0, 32'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R4 idle", 32'd0, 1'b1, 4'b0000);
  endtask

  task automatic t_logical;
    drive(4'h0, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0001, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_out("R1 AND/R7", 32'h00F0_1234, 1'b1, 4'b0011);
    drive(4'hE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_out("R1 BIC/R6/R7 keep", 32'd0, 1'b1, 4'b0110);
    drive(4'hF, 32'd0, 32'h0000_0001, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R1 MVN/R6", 32'hFFFF_FFFE, 1'b1, 4'b1000);
    drive(4'h1, 32'hAAAA_AAAA, 32'h5555_5555, 4'b0111, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R1 EOR/R4", 32'hFFFF_FFFF, 1'b1, 4'b0111);
  endtask

  task automatic t_arith;
    drive(4'h4, 32'h7FFF_FFFF, 32'd1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 ADD/R8 ovf", 32'h8000_0000, 1'b1, 4'b1001);
    drive(4'h2, 32'd5, 32'd5, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 SUB/R8 zero", 32'd0, 1'b1, 4'b0110);
    drive(4'h2, 32'd0, 32'd1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 SUB/R8 borrow", 32'hFFFF_FFFF, 1'b1, 4'b1000);
    drive(4'h5, 32'hFFFF_FFFF, 32'd0, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 ADC/R8 carry", 32'd0, 1'b1, 4'b0110);
    drive(4'h6, 32'd5, 32'd3, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 SBC", 32'd1, 1'b1, 4'b0010);
    drive(4'h7, 32'd3, 32'd5, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 RSC", 32'd1, 1'b1, 4'b0010);
    drive(4'h3, 32'd7, 32'd2, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R2 RSB", 32'hFFFF_FFFB, 1'b1, 4'b1000);
  endtask

  task automatic t_tests;
    drive(4'hA, 32'h8000_0000, 32'd1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 CMP/R8", 32'h7FFF_FFFF, 1'b0, 4'b0011);
    drive(4'h8, 32'hF000_0000, 32'h0F00_0000, 4'b1011, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 TST", 32'd0, 1'b0, 4'b0101);
    drive(4'hB, 32'hFFFF_FFFF, 32'd1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 CMN", 32'd0, 1'b0, 4'b0110);
  endtask

  task automatic t_pc;
    drive(4'h4, 32'h7FFF_FFFF, 32'd1, 4'b0100, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_out("R5 pc arith", 32'h8000_0000, 1'b1, 4'b0100);
    drive(4'h9, 32'd3, 32'd3, 4'b1010, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_out("R5 pc test", 32'd0, 1'b0, 4'b1010);
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 150; k++) begin
        logic [31:0] a, b;
        a = $urandom;
        b = $urandom;
        if (k % 10 == 0) b = a;
        if (k % 10 == 1) a = 32'h8000_0000;
        drive(4'(o), a, b, 4'($urandom), 1'($urandom), (k % 7 == 0),
              1'($urandom), 1'($urandom));
        check_model("R1 R2 R3 R4 R5 R6 R7 R8 sweep");
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: got timeout, exp completion");
        end
      end
      begin
        void'($urandom(32'h1F2E));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_logical();
        t_arith();
        t_tests();
        t_pc();
        t_sweep();
        done = 1'b1;
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule